// File: doc/BRIEF.md
# Power-Entry Packet Placement Monitor

This block is a passive bus monitor. It watches the ROW and COL request slots of a memory channel around a low-power entry command. When an entry command is seen, the monitor records the target device. It then counts cycles from that command and checks every later ROW or COL packet against four placement rules. Each rule has its own one-cycle violation pulse and its own sticky error bit. Software or a scoreboard can clear the sticky bits with a write-one-to-clear input.

The frame length, the restricted interval and the quiet interval are all runtime inputs, counted in cycles. The cycle of the entry strobe is offset 0, and the first cycle after it is offset 1. Packets in the strobe cycle itself are not checked, because the entry command occupies the ROW bus in that cycle.

A three-state controller holds the window state:

- `PW_IDLE`: no window is open.
- `PW_FRAME`: the offset is still below the frame length, so the COL rules apply.
- `PW_TAIL`: the COL rules are over, but the restricted or the quiet interval is still open.

The transitions are:

- **start**: an entry strobe in any state moves to FRAME, TAIL or IDLE, chosen for offset 1.
- **frame_end**: FRAME moves to TAIL or IDLE when the next offset reaches the frame length.
- **tail_end**: TAIL moves to IDLE when the next offset lies beyond both intervals.
- **restart**: an entry strobe while a window is open resets the offset to 1 and records the new target device.

Top module: `pwr_entry_mon`

## Requirements
- R1: After reset, all violation pulses and all sticky error bits are 0.
- R2: A COL packet to any device at offset TFRM-3, TFRM-2 or TFRM-1 raises violation bit 0 (slot).
- R3: A COL packet to the target device at any offset from 1 to TFRM-4 raises violation bit 1 (early). A COL packet to any other device at those offsets, or to any device at offset TFRM or later, raises neither bit 0 nor bit 1.
- R4: A ROW or COL packet whose device field equals the target device, at any offset from 1 to the restricted length, raises violation bit 2 (restricted). Packets to other devices do not raise it.
- R5: A ROW packet with the broadcast flag set, at any offset from 1 to the quiet length, raises violation bit 3 (quiet).
- R6: Each violation bit is a single-cycle pulse. It is asserted in the cycle after the offending packet's cycle.
- R7: Each sticky error bit is set by its violation pulse and held. A 1 on the matching clear bit clears it. If a set and a clear arrive in the same cycle, the set wins.
- R8: An entry strobe restarts the offset at 1 and records the device from the strobe, even while a window is open. Packets presented in the strobe cycle are not checked.
- R9: With no window open (before any strobe, or after every rule's last offset), no violation is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_stb | input | 1 | Low-power entry command strobe |
| entry_dev | input | DEV_W | Target device of the entry command |
| tfrm | input | CW | Frame length in cycles (4 or more) |
| restr_len | input | CW | Restricted interval length in cycles |
| quiet_len | input | CW | Quiet interval length in cycles |
| row_vld | input | 1 | ROW packet present this cycle |
| row_dev | input | DEV_W | ROW packet device field |
| row_bcast | input | 1 | ROW packet is a broadcast |
| col_vld | input | 1 | COL packet present this cycle |
| col_dev | input | DEV_W | COL packet device field |
| err_clr | input | 4 | Write-one-to-clear for the sticky bits |
| viol | output | 4 | Violation pulses: 0 slot, 1 early, 2 restricted, 3 quiet |
| err_sticky | output | 4 | Sticky error bits, same order as viol |

## Verification
The bench walks COL packets across every offset of one frame for both the target device and other devices. This targets the two slot edges, TFRM-4 and TFRM. An off-by-one in either compare would flag a legal slot, or miss one of the three forbidden slots. It also places packets at the last cycle of the restricted and quiet intervals, and retriggers an entry inside an open window. A design that failed to reset its counter or to record the new device would report violations against the stale target. Finally, it drives a clear and a set into the same cycle. A design where the clear won would lose the error.

// File: rtl/pw_mon_pkg.sv
package pw_mon_pkg;
    typedef enum logic [1:0] {
        PW_IDLE  = 2'd0,
        PW_FRAME = 2'd1,
        PW_TAIL  = 2'd2
    } pw_state_e;

    localparam int PW_NCLS     = 4;
    localparam int PW_CLS_SLOT = 0;
    localparam int PW_CLS_EARL = 1;
    localparam int PW_CLS_REST = 2;
    localparam int PW_CLS_QUIE = 3;
endpackage

// File: rtl/pwm_window_ctl.sv
module pwm_window_ctl
    import pw_mon_pkg::*;
#(
    parameter int DEV_W = 5,
    parameter int CW    = 8,
    localparam int OW   = CW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_stb,
    input  logic [DEV_W-1:0] entry_dev,
    input  logic [CW-1:0]    tfrm,
    input  logic [CW-1:0]    restr_len,
    input  logic [CW-1:0]    quiet_len,
    output pw_state_e        state,
    output logic [OW-1:0]    offset,
    output logic [DEV_W-1:0] target_dev
);
    pw_state_e        st_n;
    logic [OW-1:0]    off_n;
    logic [OW-1:0]    off_inc;
    logic [DEV_W-1:0] dev_n;

    // Choose the state that governs a given offset.
    function automatic pw_state_e pick(input logic [OW-1:0] o,
                                       input logic [CW-1:0] fr,
                                       input logic [CW-1:0] rl,
                                       input logic [CW-1:0] ql);
        if (o < {1'b0, fr})
            return PW_FRAME;
        else if (o <= {1'b0, rl} || o <= {1'b0, ql})
            return PW_TAIL;
        else
            return PW_IDLE;
    endfunction

    assign off_inc = (&offset) ? offset : offset + 1'b1;

    always_comb begin
        st_n  = state;
        off_n = offset;
        dev_n = target_dev;
        if (entry_stb) begin
            off_n = OW'(1);
            dev_n = entry_dev;
            st_n  = pick(OW'(1), tfrm, restr_len, quiet_len);
        end else begin
            unique case (state)
                PW_IDLE: begin
                    st_n = PW_IDLE;
                end
                PW_FRAME, PW_TAIL: begin
                    off_n = off_inc;
                    st_n  = pick(off_inc, tfrm, restr_len, quiet_len);
                end
                default: begin
                    st_n = PW_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= PW_IDLE;
            offset     <= '0;
            target_dev <= '0;
        end else begin
            state      <= st_n;
            offset     <= off_n;
            target_dev <= dev_n;
        end
    end

    a_r8_restart_offset: assert property (@(posedge clk) disable iff (!rst_n)
        entry_stb |=> (offset == OW'(1) && target_dev == $past(entry_dev)));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_IDLE && !entry_stb) |=> state == PW_IDLE);

    a_r3_frame_below_tfrm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_FRAME) |-> (offset < {1'b0, tfrm}));
endmodule

// File: rtl/pwm_rule_eval.sv
module pwm_rule_eval
    import pw_mon_pkg::*;
#(
    parameter int DEV_W = 5,
    parameter int CW    = 8,
    localparam int OW   = CW + 1
) (
    input  pw_state_e            state,
    input  logic [OW-1:0]        offset,
    input  logic [DEV_W-1:0]     target_dev,
    input  logic                 entry_stb,
    input  logic [CW-1:0]        tfrm,
    input  logic [CW-1:0]        restr_len,
    input  logic [CW-1:0]        quiet_len,
    input  logic                 row_vld,
    input  logic [DEV_W-1:0]     row_dev,
    input  logic                 row_bcast,
    input  logic                 col_vld,
    input  logic [DEV_W-1:0]     col_dev,
    output logic [PW_NCLS-1:0]   hit
);
    localparam int XW = OW + 1;

    logic          win_open;
    logic          col_open;
    logic [XW-1:0] off_x;
    logic [XW-1:0] frm_x;
    logic          col_tgt;
    logic          row_tgt;

    assign win_open = (state != PW_IDLE) && !entry_stb;
    assign col_open = (state == PW_FRAME) && !entry_stb;
    assign off_x    = {1'b0, offset};
    assign frm_x    = XW'(tfrm);
    assign col_tgt  = col_vld && (col_dev == target_dev);
    assign row_tgt  = row_vld && (row_dev == target_dev);

    always_comb begin
        hit = '0;
        hit[PW_CLS_SLOT] = col_open && col_vld && (off_x + XW'(3) >= frm_x);
        hit[PW_CLS_EARL] = col_open && col_tgt && (off_x + XW'(4) <= frm_x);
        hit[PW_CLS_REST] = win_open && (offset <= {1'b0, restr_len})
                           && (row_tgt || col_tgt);
        hit[PW_CLS_QUIE] = win_open && (offset <= {1'b0, quiet_len})
                           && row_vld && row_bcast;
    end
endmodule

// File: rtl/pwm_sticky.sv
module pwm_sticky
    import pw_mon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PW_NCLS-1:0] hit,
    input  logic [PW_NCLS-1:0] clr,
    output logic [PW_NCLS-1:0] pulse,
    output logic [PW_NCLS-1:0] sticky
);
    for (genvar g = 0; g < PW_NCLS; g++) begin : g_cls
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pulse[g]  <= 1'b0;
                sticky[g] <= 1'b0;
            end else begin
                pulse[g]  <= hit[g];
                sticky[g] <= hit[g] | (sticky[g] & ~clr[g]);
            end
        end

        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> sticky[g]);

        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky[g] && !clr[g]) |=> sticky[g]);
    end
endmodule

// File: rtl/pwr_entry_mon.sv
module pwr_entry_mon
    import pw_mon_pkg::*;
#(
    parameter int DEV_W = 5,
    parameter int CW    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               entry_stb,
    input  logic [DEV_W-1:0]   entry_dev,
    input  logic [CW-1:0]      tfrm,
    input  logic [CW-1:0]      restr_len,
    input  logic [CW-1:0]      quiet_len,
    input  logic               row_vld,
    input  logic [DEV_W-1:0]   row_dev,
    input  logic               row_bcast,
    input  logic               col_vld,
    input  logic [DEV_W-1:0]   col_dev,
    input  logic [3:0]         err_clr,
    output logic [3:0]         viol,
    output logic [3:0]         err_sticky
);
    localparam int OW = CW + 1;

    pw_state_e          state;
    logic [OW-1:0]      offset;
    logic [DEV_W-1:0]   target_dev;
    logic [PW_NCLS-1:0] hit;

    pwm_window_ctl #(.DEV_W(DEV_W), .CW(CW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry_stb  (entry_stb),
        .entry_dev  (entry_dev),
        .tfrm       (tfrm),
        .restr_len  (restr_len),
        .quiet_len  (quiet_len),
        .state      (state),
        .offset     (offset),
        .target_dev (target_dev)
    );

    pwm_rule_eval #(.DEV_W(DEV_W), .CW(CW)) u_eval (
        .state      (state),
        .offset     (offset),
        .target_dev (target_dev),
        .entry_stb  (entry_stb),
        .tfrm       (tfrm),
        .restr_len  (restr_len),
        .quiet_len  (quiet_len),
        .row_vld    (row_vld),
        .row_dev    (row_dev),
        .row_bcast  (row_bcast),
        .col_vld    (col_vld),
        .col_dev    (col_dev),
        .hit        (hit)
    );

    pwm_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .clr    (err_clr),
        .pulse  (viol),
        .sticky (err_sticky)
    );

    a_r2_slot_needs_col: assert property (@(posedge clk) disable iff (!rst_n)
        viol[PW_CLS_SLOT] |-> $past(col_vld));

    a_r5_quiet_needs_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        viol[PW_CLS_QUIE] |-> $past(row_vld && row_bcast));

    a_r9_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_IDLE && !entry_stb) |=> viol == '0);

    a_r8_stb_cycle_unchecked: assert property (@(posedge clk) disable iff (!rst_n)
        entry_stb |=> viol == '0);
endmodule

// File: tb/pwr_entry_mon_bench.sv
module pwr_entry_mon_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEV_W = 5;
    localparam int CW    = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             entry_stb = 1'b0;
    logic [DEV_W-1:0] entry_dev = '0;
    logic [CW-1:0]    tfrm = 8'd10;
    logic [CW-1:0]    restr_len = 8'd6;
    logic [CW-1:0]    quiet_len = 8'd3;
    logic             row_vld = 1'b0;
    logic [DEV_W-1:0] row_dev = '0;
    logic             row_bcast = 1'b0;
    logic             col_vld = 1'b0;
    logic [DEV_W-1:0] col_dev = '0;
    logic [3:0]       err_clr = '0;
    logic [3:0]       viol;
    logic [3:0]       err_sticky;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // bench model state
    bit               m_active = 0;
    int               m_off    = 0;
    logic [DEV_W-1:0] m_dev    = '0;
    logic [3:0]       m_err    = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_entry_mon #(.DEV_W(DEV_W), .CW(CW)) u_pwr_entry_mon (
        .clk(clk), .rst_n(rst_n), .entry_stb(entry_stb), .entry_dev(entry_dev),
        .tfrm(tfrm), .restr_len(restr_len), .quiet_len(quiet_len),
        .row_vld(row_vld), .row_dev(row_dev), .row_bcast(row_bcast),
        .col_vld(col_vld), .col_dev(col_dev), .err_clr(err_clr),
        .viol(viol), .err_sticky(err_sticky)
    );

    function automatic string req_name(input int b);
        case (b)
            0: return "R2 slot";
            1: return "R3 early";
            2: return "R4 restricted";
            default: return "R5 quiet";
        endcase
    endfunction

    // expected violations from the requirement text
    function automatic logic [3:0] expect_hits(input bit stb,
            input bit rv, input logic [DEV_W-1:0] rd, input bit rb,
            input bit cv, input logic [DEV_W-1:0] cd);
        logic [3:0] e = '0;
        int f = int'(tfrm);
        if (stb || !m_active) return e;                  // R8, R9
        if (cv && m_off < f && m_off + 3 >= f) e[0] = 1'b1;            // R2
        if (cv && cd == m_dev && m_off + 4 <= f) e[1] = 1'b1;          // R3
        if (m_off <= int'(restr_len) &&
            ((rv && rd == m_dev) || (cv && cd == m_dev))) e[2] = 1'b1; // R4
        if (m_off <= int'(quiet_len) && rv && rb) e[3] = 1'b1;         // R5
        return e;
    endfunction

    task automatic step(input bit stb, input logic [DEV_W-1:0] sdev,
                        input bit rv, input logic [DEV_W-1:0] rd, input bit rb,
                        input bit cv, input logic [DEV_W-1:0] cd,
                        input logic [3:0] clr);
        logic [3:0] e;
        bit bad = 0;
        entry_stb = stb; entry_dev = sdev;
        row_vld = rv; row_dev = rd; row_bcast = rb;
        col_vld = cv; col_dev = cd; err_clr = clr;
        e = expect_hits(stb, rv, rd, rb, cv, cd);
        m_err = (m_err & ~clr) | e;                      // R7: set wins
        @(posedge clk);
        @(negedge clk);
        vectors++;
        // R6: pulse visible exactly one cycle after the packet
        for (int b = 0; b < 4; b++) begin
            if (viol[b] !== e[b]) begin
                bad = 1;
                $display("FAIL %s (R6 timing) off=%0d: viol[%0d]=%b expected %b",
                         req_name(b), m_off, b, viol[b], e[b]);
            end
        end
        if (err_sticky !== m_err) begin
            bad = 1;
            $display("FAIL R7 sticky: err=%b expected %b", err_sticky, m_err);
        end
        if (bad) misses++;
        if (stb) begin
            m_active = 1; m_off = 1; m_dev = sdev;
        end else if (m_active && m_off < 100000) begin
            m_off++;
        end
    endtask

    task automatic idle_cyc(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, 0, 0, '0, '0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if (viol !== 4'd0 || err_sticky !== 4'd0) begin
            misses++;
            $display("FAIL R1 reset: viol=%b err=%b expected 0000 0000", viol, err_sticky);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R9: traffic with no window open
        step(0, '0, 1, 5'd2, 1, 1, 5'd2, '0);
        step(0, '0, 1, 5'd0, 1, 1, 5'd0, '0);

        // R2/R3/R4: COL to target at every offset, tfrm=10 restr=6 quiet=3
        step(1, 5'd2, 1, 5'd2, 1, 1, 5'd2, '0);          // R8 strobe cycle unchecked
        for (int k = 1; k <= 12; k++) step(0, '0, 0, '0, 0, 1, 5'd2, '0);
        idle_cyc(3);
        // R7: clear all, then clear and set same cycle
        step(0, '0, 0, '0, 0, 0, '0, 4'hF);
        step(1, 5'd7, 0, '0, 0, 0, '0, '0);
        step(0, '0, 0, '0, 0, 1, 5'd7, 4'hF);           // R7 set wins over clear

        // R3: COL to other device across the frame, ROW to other device
        step(1, 5'd4, 0, '0, 0, 0, '0, 4'hF);
        for (int k = 1; k <= 12; k++) step(0, '0, 1, 5'd9, 0, 1, 5'd1, '0);

        // R4/R5: edges of restricted and quiet intervals
        step(1, 5'd3, 0, '0, 0, 0, '0, 4'hF);
        for (int k = 1; k <= 8; k++) step(0, '0, 1, 5'd3, 1, 0, '0, '0);

        // R8: restart inside an open window with a new target
        step(1, 5'd1, 0, '0, 0, 0, '0, 4'hF);
        idle_cyc(4);
        step(1, 5'd6, 0, '0, 0, 0, '0, '0);
        for (int k = 1; k <= 10; k++) step(0, '0, 1, 5'd1, 0, 1, 5'd6, '0);

        // tight frame: tfrm=4, no early slots
        tfrm = 8'd4; restr_len = 8'd0; quiet_len = 8'd0;
        idle_cyc(2);
        step(1, 5'd0, 0, '0, 0, 0, '0, 4'hF);
        for (int k = 1; k <= 6; k++) step(0, '0, 0, '0, 1, 1, 5'd0, '0);

        // constrained random with fixed seed
        void'($urandom(32'h5eed_1234));
        for (int cfg = 0; cfg < 4; cfg++) begin
            tfrm      = CW'(4 + $urandom_range(0, 20));
            restr_len = CW'($urandom_range(0, 25));
            quiet_len = CW'($urandom_range(0, 25));
            idle_cyc(30);
            for (int i = 0; i < 3000; i++) begin
                bit s  = ($urandom_range(0, 39) == 0);
                bit rv = ($urandom_range(0, 3) == 0);
                bit cv = ($urandom_range(0, 2) == 0);
                step(s, DEV_W'($urandom_range(0, 3)),
                     rv, DEV_W'($urandom_range(0, 3)), $urandom_range(0, 1) == 1,
                     cv, DEV_W'($urandom_range(0, 3)),
                     ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'h0);
            end
        end
        done = 1;
        summary();
    end
endmodule